// File: doc/BRIEF.md
# Bit Scan and Bit Manipulation Unit

A purely combinational datapath slice for bit-level work on 32-bit words. Five operations are offered. Two operations scan the operand: one searches downward for its most significant 1, and the other searches upward for its least significant 0. Three operations work on a single register bit chosen by the operand: they test it, force it to 1 or force it to 0. The unit produces a result word, Z and N flag values, and a two-bit flag-write enable. The enclosing pipeline uses that enable to decide which condition flags it updates.

Bit positions run from 0 for the least significant bit to 31 for the most significant bit. When a scan finds no qualifying bit, it returns all ones (-1) and reports both Z and N as set. A successful scan returns the bit position as a non-negative number and clears both flags. The bit test leaves the register word as it is and reports its answer only through Z.

Top module: `bitops_unit`

## Requirements
- R1: With opcode 3'd1 (scan high one), and an operand that is not zero, the result is the index of the most significant 1 of the operand, zero-extended. In this case z_o=0 and n_o=0.
- R2: With opcode 3'd1 and an operand of zero, the result is 32'hFFFFFFFF and z_o=n_o=1.
- R3: With opcode 3'd2 (scan low zero), and an operand that is not all ones, the result is the index of the least significant 0 of the operand. In this case z_o=0 and n_o=0.
- R4: With opcode 3'd2 and an operand of 32'hFFFFFFFF, the result is 32'hFFFFFFFF and z_o=n_o=1.
- R5: Both scan opcodes drive flag_we_o=2'b11. Bit 0 of flag_we_o enables the Z write and bit 1 enables the N write.
- R6: With opcode 3'd3 (bit test), z_o is 1 exactly when the selected register bit is 0, n_o=0, flag_we_o=2'b01, and the result equals the register input.
- R7: With opcode 3'd4 (bit set), the result is the register with the selected bit forced to 1. flag_we_o=2'b00 and z_o=n_o=0.
- R8: With opcode 3'd5 (bit clear), the result is the register with the selected bit forced to 0. flag_we_o=2'b00 and z_o=n_o=0.
- R9: For opcodes 3'd3 to 3'd5, only operand bits [4:0] select the bit position. Operand bits [31:5] have no effect on any output.
- R10: Opcodes 3'd0, 3'd6 and 3'd7 are idle. The result equals the register, flag_we_o=2'b00, and z_o=n_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation code |
| reg_i | input | 32 | Register value |
| operand_i | input | 32 | Scan source, or bit selector in its low 5 bits |
| result_o | output | 32 | Result word |
| z_o | output | 1 | Z flag value (0 when not written) |
| n_o | output | 1 | N flag value (0 when not written) |
| flag_we_o | output | 2 | Flag write enables: bit 0 for Z, bit 1 for N |

## Verification
The assertions assume that every input is a known value and that the inputs have settled whenever the combinational checks are evaluated. The bench meets this by driving all inputs together on the falling clock edge and sampling one nanosecond later. The stimulus runs through every bit position for both scans, with random bits on the side the scan never reaches. It also runs every selector value against fixed and random register words, with random upper operand bits, so each opcode is applied only with values that are fully defined.

// File: rtl/bitops_pkg.sv
package bitops_pkg;
  typedef enum logic [2:0] {
    BOP_IDLE    = 3'd0,
    BOP_HI_ONE  = 3'd1,
    BOP_LO_ZERO = 3'd2,
    BOP_TEST    = 3'd3,
    BOP_SET     = 3'd4,
    BOP_CLEAR   = 3'd5
  } bop_e;

  localparam int FLAG_Z = 0;
  localparam int FLAG_N = 1;
endpackage

// File: rtl/bitscan_pri.sv
// Priority scanner: finds the highest (FROM_TOP=1) or lowest set bit.
module bitscan_pri #(
  parameter int WIDTH    = 32,
  parameter bit FROM_TOP = 1'b1,
  localparam int IDXW    = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic             hit_o,
  output logic [IDXW-1:0]  pos_o
);
  // later matches overwrite earlier ones: ascending loop keeps the highest
  function automatic logic [IDXW:0] scan_highest(input logic [WIDTH-1:0] v);
    logic [IDXW:0] r;
    r = '0;
    for (int i = 0; i < WIDTH; i++)
      if (v[i]) r = {1'b1, IDXW'(i)};
    return r;
  endfunction

  function automatic logic [IDXW:0] scan_lowest(input logic [WIDTH-1:0] v);
    logic [IDXW:0] r;
    r = '0;
    for (int i = WIDTH - 1; i >= 0; i--)
      if (v[i]) r = {1'b1, IDXW'(i)};
    return r;
  endfunction

  logic [IDXW:0] found;

  generate
    if (FROM_TOP) begin : g_top
      assign found = scan_highest(vec_i);
    end else begin : g_bot
      assign found = scan_lowest(vec_i);
    end
  endgenerate

  assign hit_o = found[IDXW];
  assign pos_o = found[IDXW-1:0];

  // R2 R4
  always_comb hit_any_chk: assert (hit_o == (vec_i != '0));

  // R1 R3
  always_comb hit_bit_chk: assert (!hit_o || vec_i[pos_o]);

  generate
    if (FROM_TOP) begin : g_top_chk
      // R1
      always_comb top_order_chk: assert (!hit_o || ((vec_i >> pos_o) == WIDTH'(1)));
    end else begin : g_bot_chk
      // R3
      always_comb bot_order_chk:
        assert (!hit_o || ((vec_i & ((WIDTH'(1) << pos_o) - WIDTH'(1))) == '0));
    end
  endgenerate
endmodule

// File: rtl/bit_modify.sv
// Single-bit test / set / clear on a register word.
module bit_modify #(
  parameter int WIDTH = 32,
  localparam int IDXW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] reg_i,
  input  logic [IDXW-1:0]  sel_i,
  output logic             bit_o,
  output logic [WIDTH-1:0] set_o,
  output logic [WIDTH-1:0] clr_o
);
  function automatic logic [WIDTH-1:0] onehot(input logic [IDXW-1:0] s);
    return WIDTH'(1) << s;
  endfunction

  logic [WIDTH-1:0] mask;
  assign mask  = onehot(sel_i);
  assign bit_o = |(reg_i & mask);
  assign set_o = reg_i | mask;
  assign clr_o = reg_i & ~mask;

  // R7
  always_comb set_one_chk: assert (set_o[sel_i] && $countones(set_o ^ reg_i) <= 1);

  // R8
  always_comb clr_one_chk: assert (!clr_o[sel_i] && $countones(clr_o ^ reg_i) <= 1);
endmodule

// File: rtl/bitops_unit.sv
module bitops_unit
  import bitops_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int IDXW = $clog2(WIDTH)
) (
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] reg_i,
  input  logic [WIDTH-1:0] operand_i,
  output logic [WIDTH-1:0] result_o,
  output logic             z_o,
  output logic             n_o,
  output logic [1:0]       flag_we_o
);
  bop_e op;
  assign op = bop_e'(op_i);

  // named internal events for the checks
  logic             hi_hit, lo_hit, sel_bit;
  logic [IDXW-1:0]  hi_pos, lo_pos, sel;
  logic [WIDTH-1:0] set_word, clr_word;
  logic             is_scan;

  // R9: only the low IDXW bits choose the bit
  assign sel = operand_i[IDXW-1:0];

  bitscan_pri #(.WIDTH(WIDTH), .FROM_TOP(1'b1)) u_hi (
    .vec_i(operand_i), .hit_o(hi_hit), .pos_o(hi_pos));

  // the lowest zero is the lowest one of the inverted operand
  bitscan_pri #(.WIDTH(WIDTH), .FROM_TOP(1'b0)) u_lo (
    .vec_i(~operand_i), .hit_o(lo_hit), .pos_o(lo_pos));

  bit_modify #(.WIDTH(WIDTH)) u_mod (
    .reg_i(reg_i), .sel_i(sel), .bit_o(sel_bit),
    .set_o(set_word), .clr_o(clr_word));

  function automatic logic [WIDTH-1:0] scan_word(input logic hit, input logic [IDXW-1:0] pos);
    return hit ? WIDTH'(pos) : '1;
  endfunction

  assign is_scan = (op == BOP_HI_ONE) || (op == BOP_LO_ZERO);

  always_comb begin
    result_o  = reg_i;
    z_o       = 1'b0;
    n_o       = 1'b0;
    flag_we_o = 2'b00;
    unique case (op)
      BOP_HI_ONE: begin
        result_o  = scan_word(hi_hit, hi_pos);
        z_o       = ~hi_hit;
        n_o       = ~hi_hit;
        flag_we_o = 2'b11;
      end
      BOP_LO_ZERO: begin
        result_o  = scan_word(lo_hit, lo_pos);
        z_o       = ~lo_hit;
        n_o       = ~lo_hit;
        flag_we_o = 2'b11;
      end
      BOP_TEST: begin
        z_o               = ~sel_bit;
        flag_we_o[FLAG_Z] = 1'b1;
      end
      BOP_SET:   result_o = set_word;
      BOP_CLEAR: result_o = clr_word;
      default: ;
    endcase
  end

  // R5
  always_comb scan_flags_chk: assert (!is_scan || (flag_we_o == 2'b11 && z_o == n_o));

  // R2
  always_comb scan_sign_chk: assert (!is_scan || (z_o == result_o[WIDTH-1]));

  // R6
  always_comb test_keep_chk:
    assert (op != BOP_TEST || (result_o == reg_i && flag_we_o == 2'b01 && !n_o));

  // R6
  always_comb test_z_chk: assert (op != BOP_TEST || (z_o == !reg_i[operand_i[IDXW-1:0]]));

  // R7 R8
  always_comb modify_noflag_chk:
    assert (!(op == BOP_SET || op == BOP_CLEAR) || (flag_we_o == 2'b00 && !z_o && !n_o));

  // R10
  always_comb idle_chk:
    assert ((is_scan || op == BOP_TEST || op == BOP_SET || op == BOP_CLEAR) ||
            (result_o == reg_i && flag_we_o == 2'b00 && !z_o && !n_o));
endmodule

// File: tb/bitops_unit_test.sv
`timescale 1ns/1ps
module bitops_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0]  op;
  logic [31:0] rv, od;
  logic [31:0] res;
  logic        z, n;
  logic [1:0]  we;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  bitops_unit uut (.op_i(op), .reg_i(rv), .operand_i(od),
                   .result_o(res), .z_o(z), .n_o(n), .flag_we_o(we));

  function automatic int top_one(input logic [31:0] v);
    for (int i = 31; i >= 0; i--) if (v[i]) return i;
    return -1;
  endfunction

  function automatic int bottom_zero(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (!v[i]) return i;
    return -1;
  endfunction

  task automatic drive(input logic [2:0] o, input logic [31:0] r, input logic [31:0] d);
    @(negedge clk);
    op = o; rv = r; od = d;
    #1;
  endtask

  task automatic expect_all(input string req, input logic [31:0] er,
                            input logic ez, input logic en, input logic [1:0] ew);
    vectors++;
    if (res !== er || z !== ez || n !== en || we !== ew) begin
      errors++;
      $display("FAIL %s op=%0d reg=%h opd=%h: got res=%h z=%b n=%b we=%b, expected res=%h z=%b n=%b we=%b",
               req, op, rv, od, res, z, n, we, er, ez, en, ew);
    end
  endtask

  initial begin
    op = 3'd0; rv = '0; od = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R10: quiet state with idle opcode
    drive(3'd0, 32'h0, 32'h0);
    expect_all("R10", 32'h0, 1'b0, 1'b0, 2'b00);

    // R1 R5: highest one at every position, random bits below it
    for (int p = 0; p < 32; p++) begin
      for (int t = 0; t < 4; t++) begin
        logic [31:0] v;
        v = (32'(1) << p) | ($urandom() & ((32'(1) << p) - 32'(1)));
        drive(3'd1, $urandom(), v);
        expect_all("R1", 32'(top_one(v)), 1'b0, 1'b0, 2'b11);
      end
    end
    // R2
    drive(3'd1, 32'h1234_5678, 32'h0);
    expect_all("R2", 32'hFFFF_FFFF, 1'b1, 1'b1, 2'b11);

    // R3 R5: lowest zero at every position, random bits above it
    for (int p = 0; p < 32; p++) begin
      for (int t = 0; t < 4; t++) begin
        logic [31:0] v;
        v = ((32'(1) << p) - 32'(1)) | ($urandom() & ~((32'(1) << (p + 1)) - 32'(1)));
        v[p] = 1'b0;
        drive(3'd2, $urandom(), v);
        expect_all("R3", 32'(bottom_zero(v)), 1'b0, 1'b0, 2'b11);
      end
    end
    // R4
    drive(3'd2, 32'h0, 32'hFFFF_FFFF);
    expect_all("R4", 32'hFFFF_FFFF, 1'b1, 1'b1, 2'b11);

    // R6 R7 R8 R9: every selector over several words, random upper operand bits
    for (int k = 0; k < 6; k++) begin
      logic [31:0] w;
      case (k)
        0: w = 32'h0000_0000;
        1: w = 32'hFFFF_FFFF;
        2: w = 32'hA5A5_5A5A;
        default: w = $urandom();
      endcase
      for (int p = 0; p < 32; p++) begin
        logic [31:0] d;
        d = {27'($urandom()), 5'(p)};
        drive(3'd3, w, d);
        expect_all("R6/R9", w, ~w[p], 1'b0, 2'b01);
        drive(3'd4, w, d);
        expect_all("R7/R9", w | (32'(1) << p), 1'b0, 1'b0, 2'b00);
        drive(3'd5, w, d);
        expect_all("R8/R9", w & ~(32'(1) << p), 1'b0, 1'b0, 2'b00);
      end
    end

    // R10: idle opcodes with random data
    for (int t = 0; t < 20; t++) begin
      logic [2:0]  o;
      logic [31:0] w;
      o = (t % 3 == 0) ? 3'd0 : (t % 3 == 1) ? 3'd6 : 3'd7;
      w = $urandom();
      drive(o, w, $urandom());
      expect_all("R10", w, 1'b0, 1'b0, 2'b00);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule